// File: doc/BRIEF.md
# Edge Event Request Unit

This block turns transitions on general-purpose input pins into service-request pulses for an interrupt controller. It holds eight request lines, arranged as two identical units of four channels. Each channel picks one pin out of a shared input bus, brings it into the clock domain through a two-flop synchroniser and looks for rising edges, falling edges or both. Each detected edge of the chosen kind sends a one-cycle pulse on that channel's request line, as long as the channel's pulse enable is set.

Each channel also has a status flag that hardware keeps up to date. The chosen edge sets the flag and the opposite edge clears it, so after the first event the flag follows the pin's logical level. In both-edge mode the flag toggles instead. With this flag, software can treat an edge-only interrupt path as a level interrupt: it polls the flag after servicing and can write the flag itself to force a pending condition or to discard one.

Configuration uses one write port and one combinational read port. The write address picks either a channel's configuration word or its flag.

Top module: `edge_event_unit`

## Requirements
- R1: While rst_n is low, every sr_o bit is low. After reset every channel reads back mode 01 (rising), source 0, pulse enable 0 and flag 0.
- R2: A pin change sampled at clock edge N shows on the matching sr_o bit for exactly the cycle after edge N+2. No request line reacts earlier.
- R3: The mode field is bits [5:4] of the data word. 01 detects rising edges, 10 detects falling edges, 11 detects both and 00 detects none. A request pulse is produced only for an edge the mode selects.
- R4: In mode 01 the flag is set by a rising edge and cleared by a falling edge. In mode 10 the roles are swapped. In mode 00 the flag holds.
- R5: In mode 11 the flag inverts on every edge of the selected input.
- R6: An input that stays high or low produces no request pulse, however long it is held.
- R7: Pulse enable is bit [6] of the data word. When it is 0 the channel's sr_o stays low, and its flag keeps updating exactly as it would with the enable set.
- R8: A write with wr_addr[3]=1 loads data bit [7] into the flag of line wr_addr[2:0] at the next edge. This write wins over a hardware flag update in the same cycle and does not change that cycle's request pulse.
- R9: A write with wr_addr[3]=0 loads the source field (bits [3:0]), the mode and the pulse enable of line wr_addr[2:0]. That line reports no edge in the write cycle and leaves its flag alone. Its edge reference is reloaded from the newly selected source, so choosing a source whose level differs from the old one raises no request.
- R10: Line l belongs to unit l[2], channel l[1:0], and drives sr_o[l] and flag_o[l]. rd_data returns {flag, enable, mode, source} of line rd_line.
- R11: A channel reacts only to gpio_i[source]. Transitions on any other pin leave its request line and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gpio_i | input | NUM_IN (16) | Asynchronous input pins |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | LINE_W+1 (4) | Bit [3] selects flag (1) or configuration (0); bits [2:0] select the line |
| wr_data | input | SEL_W+4 (8) | {flag, enable, mode[1:0], source[3:0]} |
| rd_line | input | LINE_W (3) | Line whose state appears on rd_data |
| rd_data | output | SEL_W+4 (8) | {flag, enable, mode[1:0], source[3:0]} of rd_line |
| flag_o | output | NUM_LINES (8) | Status flag per line |
| sr_o | output | NUM_LINES (8) | Service-request pulse per line |

## Verification
A pin change driven before clock edge N can first produce a request pulse and a new flag value after edge N+2. Register writes take effect at the edge that samples them, and rd_data follows at once. The bench feeds every input change and write into a behavioural model at the same edge the design sees it, delays pin samples by two entries in a history queue, and compares sr_o, flag_o and rd_data at each falling clock edge. It sweeps rd_line so that all lines get compared. Directed checks also count the falling edges after a pin change and require the pulse to appear at the third one and not before.

// File: rtl/edge_event_unit.sv
`timescale 1ns/1ps
module edge_event_unit #(
  parameter int NUM_UNITS   = 2,
  parameter int CH_PER_UNIT = 4,
  parameter int NUM_IN      = 16
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic [NUM_IN-1:0]                      gpio_i,
  input  logic                                   wr_en,
  input  logic [$clog2(NUM_UNITS*CH_PER_UNIT):0] wr_addr,
  input  logic [$clog2(NUM_IN)+3:0]              wr_data,
  input  logic [$clog2(NUM_UNITS*CH_PER_UNIT)-1:0] rd_line,
  output logic [$clog2(NUM_IN)+3:0]              rd_data,
  output logic [NUM_UNITS*CH_PER_UNIT-1:0]       flag_o,
  output logic [NUM_UNITS*CH_PER_UNIT-1:0]       sr_o
);
  localparam int NUM_LINES = NUM_UNITS * CH_PER_UNIT;
  localparam int LINE_W    = $clog2(NUM_LINES);
  localparam int SEL_W     = $clog2(NUM_IN);
  localparam int MODE_LSB  = SEL_W;
  localparam int PE_BIT    = SEL_W + 2;
  localparam int FLAG_BIT  = SEL_W + 3;
  localparam logic [1:0] M_RISE = 2'b01;
  localparam logic [1:0] M_FALL = 2'b10;
  localparam logic [1:0] M_BOTH = 2'b11;

  logic [NUM_IN-1:0] sync_a, sync_b;
  logic [NUM_LINES-1:0][SEL_W-1:0] sel_v;
  logic [NUM_LINES-1:0][1:0]       mode_v;
  logic [NUM_LINES-1:0] pe_v, flag_v, prev_v, cur_v;
  logic [NUM_LINES-1:0] rise_v, fall_v, hit_v, flag_nx;
  logic [NUM_LINES-1:0] cfg_wr_v, flag_wr_v;
  logic [SEL_W-1:0]     new_sel;

  assign new_sel = wr_data[SEL_W-1:0];
  assign rise_v  = cur_v & ~prev_v;
  assign fall_v  = ~cur_v & prev_v;

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      cfg_wr_v[l]  = wr_en && !wr_addr[LINE_W] && (wr_addr[LINE_W-1:0] == LINE_W'(l));
      flag_wr_v[l] = wr_en &&  wr_addr[LINE_W] && (wr_addr[LINE_W-1:0] == LINE_W'(l));
      cur_v[l]     = sync_b[sel_v[l]];
      case (mode_v[l])
        M_RISE: begin
          hit_v[l]   = rise_v[l];
          flag_nx[l] = rise_v[l] | (flag_v[l] & ~fall_v[l]);
        end
        M_FALL: begin
          hit_v[l]   = fall_v[l];
          flag_nx[l] = fall_v[l] | (flag_v[l] & ~rise_v[l]);
        end
        M_BOTH: begin
          hit_v[l]   = rise_v[l] | fall_v[l];
          flag_nx[l] = flag_v[l] ^ (rise_v[l] | fall_v[l]);
        end
        default: begin
          hit_v[l]   = 1'b0;
          flag_nx[l] = flag_v[l];
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sel_v  <= '0;
      pe_v   <= '0;
      flag_v <= '0;
      prev_v <= '0;
      sr_o   <= '0;
      for (int l = 0; l < NUM_LINES; l++) mode_v[l] <= M_RISE;
    end else begin
      sync_a <= gpio_i;
      sync_b <= sync_a;
      for (int l = 0; l < NUM_LINES; l++) begin
        if (cfg_wr_v[l]) begin
          sel_v[l]  <= new_sel;
          mode_v[l] <= wr_data[MODE_LSB +: 2];
          pe_v[l]   <= wr_data[PE_BIT];
          prev_v[l] <= sync_b[new_sel];
          sr_o[l]   <= 1'b0;
        end else begin
          prev_v[l] <= cur_v[l];
          sr_o[l]   <= pe_v[l] & hit_v[l];
          flag_v[l] <= flag_wr_v[l] ? wr_data[FLAG_BIT] : flag_nx[l];
        end
      end
    end
  end

  assign flag_o  = flag_v;
  assign rd_data = {flag_v[rd_line], pe_v[rd_line], mode_v[rd_line], sel_v[rd_line]};
endmodule

// File: rtl/edge_event_unit_checker.sv
`timescale 1ns/1ps
module edge_event_unit_checker #(
  parameter int NUM_LINES = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [NUM_LINES-1:0]       sr_o,
  input logic [NUM_LINES-1:0]       flag_o,
  input logic [NUM_LINES-1:0]       pe_v,
  input logic [NUM_LINES-1:0]       cur_v,
  input logic [NUM_LINES-1:0]       prev_v,
  input logic [NUM_LINES-1:0]       cfg_wr_v,
  input logic [NUM_LINES-1:0]       flag_wr_v,
  input logic [NUM_LINES-1:0][1:0]  mode_v,
  input logic                       wr_flag_bit
);
  a_r1_quiet_in_reset: assert property (@(posedge clk) !rst_n |-> sr_o == '0);

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_line
    a_r6_pulse_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      sr_o[l] |-> $past(cur_v[l] != prev_v[l]));
    a_r7_pulse_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      sr_o[l] |-> $past(pe_v[l]));
    a_r9_cfg_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_v[l] |=> !sr_o[l]);
    a_r8_flag_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
      flag_wr_v[l] |=> flag_o[l] == $past(wr_flag_bit));
    a_r5_both_toggles: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_v[l]) == 2'b11 && sr_o[l] && !$past(flag_wr_v[l]))
        |-> flag_o[l] != $past(flag_o[l]));
  end
endmodule

bind edge_event_unit edge_event_unit_checker #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sr_o        (sr_o),
  .flag_o      (flag_o),
  .pe_v        (pe_v),
  .cur_v       (cur_v),
  .prev_v      (prev_v),
  .cfg_wr_v    (cfg_wr_v),
  .flag_wr_v   (flag_wr_v),
  .mode_v      (mode_v),
  .wr_flag_bit (wr_data[FLAG_BIT])
);

// File: tb/tb_edge_event_unit.sv
`timescale 1ns/1ps
module tb_edge_event_unit;
  localparam int NL = 8;
  localparam int NIN = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NIN-1:0] gpio_i = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [2:0]    rd_line = '0;
  logic [7:0]    rd_data;
  logic [NL-1:0] flag_o, sr_o;

  edge_event_unit dut (
    .clk(clk), .rst_n(rst_n), .gpio_i(gpio_i), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_line(rd_line), .rd_data(rd_data), .flag_o(flag_o), .sr_o(sr_o)
  );

  always #2.5 clk = ~clk;

  int    checks = 0;
  int    errs = 0;
  string tag = "R1";

  logic [NIN-1:0] hist[$];
  logic [1:0] m_mode[NL];
  logic [3:0] m_sel[NL];
  logic       m_pe[NL], m_flag[NL], m_prev[NL], m_sr[NL];

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = {};
      repeat (4) hist.push_front('0);
      for (int l = 0; l < NL; l++) begin
        m_mode[l] = 2'b01; m_sel[l] = 0; m_pe[l] = 0;
        m_flag[l] = 0; m_prev[l] = 0; m_sr[l] = 0;
      end
    end else begin
      logic [NIN-1:0] seen;
      hist.push_front(gpio_i);
      if (hist.size() > 4) void'(hist.pop_back());
      seen = hist[2];
      for (int l = 0; l < NL; l++) begin
        if (wr_en && !wr_addr[3] && wr_addr[2:0] == l[2:0]) begin
          m_sel[l]  = wr_data[3:0];
          m_mode[l] = wr_data[5:4];
          m_pe[l]   = wr_data[6];
          m_prev[l] = seen[wr_data[3:0]];
          m_sr[l]   = 0;
        end else begin
          logic now_v, up, down, fire;
          now_v = seen[m_sel[l]];
          up    = now_v && !m_prev[l];
          down  = !now_v && m_prev[l];
          fire  = 0;
          if (m_mode[l] == 2'b01) begin
            fire = up;
            if (up) m_flag[l] = 1; else if (down) m_flag[l] = 0;
          end else if (m_mode[l] == 2'b10) begin
            fire = down;
            if (down) m_flag[l] = 1; else if (up) m_flag[l] = 0;
          end else if (m_mode[l] == 2'b11) begin
            fire = up || down;
            if (fire) m_flag[l] = !m_flag[l];
          end
          m_prev[l] = now_v;
          m_sr[l]   = m_pe[l] && fire;
          if (wr_en && wr_addr[3] && wr_addr[2:0] == l[2:0]) m_flag[l] = wr_data[7];
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [NL-1:0] esr, efl;
    int r;
    r = int'(rd_line) + 1;
    rd_line = r[2:0];
    #1;
    for (int l = 0; l < NL; l++) begin
      esr[l] = m_sr[l];
      efl[l] = m_flag[l];
    end
    check(tag, "sr_o", 32'(sr_o), 32'(esr));
    check(tag, "flag_o", 32'(flag_o), 32'(efl));
    check(tag, "rd_data", 32'(rd_data),
          32'({m_flag[rd_line], m_pe[rd_line], m_mode[rd_line], m_sel[rd_line]}));
  end

  task automatic wr_cfg(int line, logic [1:0] mode, logic [3:0] sel, logic pe);
    @(negedge clk);
    wr_en = 1; wr_addr = {1'b0, 3'(line)}; wr_data = {1'b0, pe, mode, sel};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic wr_flag(int line, logic v);
    @(negedge clk);
    wr_en = 1; wr_addr = {1'b1, 3'(line)}; wr_data = {v, 7'h0};
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic set_pin(int idx, logic v);
    @(negedge clk);
    gpio_i[idx] = v;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wiggle(int lo, int hi, int cycles);
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if ($urandom_range(0, 2) == 0) begin
        int idx;
        idx = $urandom_range(lo, hi);
        gpio_i[idx] = ~gpio_i[idx];
      end
    end
  endtask

  initial begin
    #1_000_000;
    errs++;
    $display("FAIL watchdog: actual=running expected=finished");
    finish_run();
  end

  initial begin
    tag = "R1";
    idle(4);
    check("R1", "sr_o in reset", 32'(sr_o), 0);
    @(negedge clk);
    rst_n = 1;
    idle(2);

    tag = "R10";
    wr_cfg(5, 2'b01, 4'd3, 1'b1);
    idle(3);
    tag = "R2";
    set_pin(3, 1);
    @(negedge clk);
    check("R2", "sr_o one edge after change", 32'(sr_o), 0);
    @(negedge clk);
    check("R2", "sr_o two edges after change", 32'(sr_o), 0);
    @(negedge clk);
    check("R10", "sr_o line 5 only", 32'(sr_o), 32'h20);
    @(negedge clk);
    check("R2", "pulse lasts one cycle", 32'(sr_o), 0);
    check("R4", "flag line 5 set", 32'(flag_o), 32'h20);
    set_pin(3, 0);
    idle(4);
    check("R4", "flag line 5 cleared by fall", 32'(flag_o), 0);

    tag = "R3";
    wr_cfg(0, 2'b01, 4'd0, 1'b1);
    wr_cfg(1, 2'b01, 4'd1, 1'b1);
    wr_cfg(2, 2'b10, 4'd2, 1'b1);
    wr_cfg(3, 2'b10, 4'd3, 1'b1);
    wr_cfg(4, 2'b11, 4'd4, 1'b1);
    wr_cfg(5, 2'b11, 4'd5, 1'b1);
    wr_cfg(6, 2'b00, 4'd6, 1'b1);
    wr_cfg(7, 2'b01, 4'd7, 1'b0);
    idle(3);
    wiggle(0, 3, 300);

    tag = "R5";
    wiggle(4, 6, 200);

    tag = "R7";
    wiggle(7, 7, 120);

    tag = "R6";
    idle(60);
    check("R6", "no pulse on steady inputs", 32'(sr_o), 0);

    tag = "R11";
    wiggle(8, 15, 200);

    tag = "R8";
    set_pin(0, 0);
    idle(4);
    wr_flag(0, 1);
    idle(1);
    check("R8", "flag line 0 forced set", 32'(flag_o[0]), 1);
    wr_flag(0, 0);
    idle(1);
    check("R8", "flag line 0 forced clear", 32'(flag_o[0]), 0);
    set_pin(0, 1);
    @(negedge clk);
    wr_flag(0, 0);
    check("R8", "pulse kept with flag write", 32'(sr_o[0]), 1);
    check("R8", "software write beats rise", 32'(flag_o[0]), 0);
    idle(3);

    tag = "R9";
    gpio_i[0] = 0;
    gpio_i[9] = 1;
    idle(4);
    wr_cfg(0, 2'b01, 4'd9, 1'b1);
    idle(4);
    check("R9", "no pulse after source change", 32'(sr_o[0]), 0);
    set_pin(9, 0);
    idle(4);
    set_pin(9, 1);
    idle(4);
    wr_flag(2, 1);
    wr_cfg(2, 2'b01, 4'd12, 1'b1);
    idle(2);
    check("R9", "config write keeps flag", 32'(flag_o[2]), 1);
    wiggle(9, 12, 200);

    idle(5);
    finish_run();
  end
endmodule